// File: doc/BRIEF.md
# SCSI Controller Register and Counter Interface

This block is the byte-wide register front end of a SCSI protocol controller. A host reads and writes single-byte registers through a simple strobe port. Behind that port sit four pieces of state. The first is a 24-bit DMA transfer counter, which the host loads by writing a start-count shadow and then issuing a command with the DMA flag set. The second is a 16-byte data FIFO. The third is a set of status, interrupt and sequence-step registers. The fourth is a level interrupt output that is high whenever any interrupt bit is pending.

The protocol core outside this block feeds it in two ways. A one-cycle event pulse ORs bits into the status and interrupt registers and loads the sequence step. A one-cycle step pulse decrements the live transfer counter.

Some reads have side effects:
- Reading the interrupt register clears the pending interrupt, the terminal-count status bit and the sequence step in one go.
- Reading the data register pops the FIFO.
- Until the high count byte has been written once after reset, reading it returns a fixed chip-identification byte.

Top module: `scsi_regif`

## Requirements
- R1: Register addresses (4-bit `bus_addr`) are 0x0 count low, 0x1 count middle, 0x9 count high, 0x2 FIFO data, 0x3 command, 0x4 status (read), 0x5 interrupt (read), 0x6 sequence step (read), 0x7 FIFO flags (read), 0x8 config 1 (read/write). Writes to the three count addresses land in a start-count shadow, and reads of them return the live counter. Read data appears on `bus_rdata` in the cycle after the read strobe. Writes to read-only addresses are ignored.
- R2: A write to any count byte clears the terminal-count status bit (status bit 4).
- R3: Writing a command with bit 7 set copies the start count into the live counter. A start count of zero loads 0x010000.
- R4: A `dma_step` pulse decrements a nonzero live counter by one, and a zero counter stays at zero. The step that brings the counter from 1 to 0 sets status bit 4.
- R5: A read of the interrupt register returns its current value. From the next cycle the interrupt register is 0x00, status bit 4 is clear and the sequence step is 0, unless a core event in the same cycle sets them again.
- R6: The FIFO flags register returns the number of bytes held in the data FIFO in bits 4:0, with bits 7:5 zero.
- R7: Until the count-high byte has been written after reset, reading it returns the `CHIP_ID` parameter (default 0xA2). After that write it returns live counter bits 23:16.
- R8: The FIFO holds 16 bytes and returns them in write order. A write while the FIFO is full is discarded, leaves the contents unchanged, and pulses `fifo_ovf` high for the following cycle.
- R9: Reading the FIFO data register while the FIFO is empty returns 0x00 and leaves the count at zero.
- R10: Command code 0x01 (bits 6:0) empties the FIFO. Command code 0x00 without bit 7 changes neither the FIFO nor the counter.
- R11: While the last command written is exactly 0x10 (non-DMA transfer), every FIFO data write sets interrupt bits 3 (function complete) and 4 (bus service).
- R12: `irq` and status bit 7 are high exactly when the interrupt register is nonzero. They stay high across further interrupt bits and fall only when the register is cleared.
- R13: After reset, status, interrupt, sequence step, counter, shadow and FIFO count are all zero, `irq` is low, and config 1 reads 0x07.
- R14: An `evt_valid` pulse ORs `evt_stat` into status bits 6:0, ORs `evt_intr` into the interrupt register, and loads `evt_seq` into the sequence step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| dma_step | input | 1 | Decrement live transfer counter |
| evt_valid | input | 1 | Core event pulse |
| evt_stat | input | 7 | Status bits to set on event |
| evt_intr | input | 8 | Interrupt bits to set on event |
| evt_seq | input | 3 | Sequence step loaded on event |
| irq | output | 1 | Level interrupt |
| fifo_ovf | output | 1 | One-cycle pulse after a discarded FIFO write |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are never high in the same cycle. This matters because each register port is single-ported: a FIFO push and pop, or a command write and an interrupt read, never collide. The clearing properties also assume no core event or counter-reaching-zero step coincides with the read or write being checked, and they exclude those cases in their antecedents. The bench drives every access through tasks that raise one strobe for exactly one cycle. Core events and steps are issued only between bus accesses, so the stimulus never leaves this envelope.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  localparam int TC_W = 24;
  localparam int TC_NB = TC_W / 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_MID = 4'h1;
  localparam logic [ADDR_W-1:0] A_FIFO    = 4'h2;
  localparam logic [ADDR_W-1:0] A_CMD     = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'h4;
  localparam logic [ADDR_W-1:0] A_INTR    = 4'h5;
  localparam logic [ADDR_W-1:0] A_SEQ     = 4'h6;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 4'h7;
  localparam logic [ADDR_W-1:0] A_CFG1    = 4'h8;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'h9;

  localparam int ST_TC     = 4;
  localparam int IN_FDONE  = 3;
  localparam int IN_BSVC   = 4;
  localparam int CMD_DMA   = 7;

  localparam logic [6:0] OP_NOP   = 7'h00;
  localparam logic [6:0] OP_FLUSH = 7'h01;
  localparam logic [6:0] OP_XFER  = 7'h10;
  localparam logic [7:0] CFG1_RST = 8'h07;

  // Live counter value produced by a DMA reload command.
  function automatic logic [TC_W-1:0] tc_reload(input logic [TC_W-1:0] stc);
    return (stc == '0) ? TC_W'(32'h0001_0000) : stc;
  endfunction

  // Interrupt bits raised by one non-DMA data byte.
  function automatic logic [7:0] xfer_intr_bits();
    logic [7:0] v;
    v = '0;
    v[IN_FDONE] = 1'b1;
    v[IN_BSVC] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/scsi_regif_tc.sv
module scsi_regif_tc
  import scsi_regif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TC_NB-1:0] shadow_we,
  input  logic [7:0]      wdata,
  input  logic            reload,
  input  logic            step,
  output logic [TC_W-1:0] tc_q,
  output logic [TC_W-1:0] stc_q,
  output logic            hit_zero
);
  assign hit_zero = step && !reload && (tc_q == TC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stc_q <= '0;
    end else begin
      for (int b = 0; b < TC_NB; b++) begin
        if (shadow_we[b]) stc_q[8*b +: 8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
    end else if (reload) begin
      tc_q <= tc_reload(stc_q);
    end else if (step && tc_q != '0) begin
      tc_q <= tc_q - TC_W'(1);
    end
  end
endmodule

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic          full, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (cnt != '0);
  assign dout    = (cnt != '0) ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= push && full;
      if (flush) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= wp + PW'(1);
        if (do_pop)  rp <= rp + PW'(1);
        case ({do_push, do_pop})
          2'b10:   cnt <= cnt + CW'(1);
          2'b01:   cnt <= cnt - CW'(1);
          default: cnt <= cnt;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_regif_irqs.sv
module scsi_regif_irqs
  import scsi_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic [6:0] evt_stat,
  input  logic [7:0] evt_intr,
  input  logic [2:0] evt_seq,
  input  logic       intr_rd,
  input  logic       tc_clr,
  input  logic       tc_set,
  input  logic       xfer_byte,
  output logic [6:0] stat_q,
  output logic [7:0] intr_q,
  output logic [2:0] seq_q,
  output logic       irq
);
  logic [6:0] stat_n;
  logic [7:0] intr_n;
  logic [2:0] seq_n;

  always_comb begin
    intr_n = intr_rd ? 8'h00 : intr_q;
    if (xfer_byte) intr_n = intr_n | xfer_intr_bits();
    if (evt_valid) intr_n = intr_n | evt_intr;

    stat_n = stat_q;
    if (intr_rd || tc_clr) stat_n[ST_TC] = 1'b0;
    if (tc_set) stat_n[ST_TC] = 1'b1;
    if (evt_valid) stat_n = stat_n | evt_stat;

    seq_n = intr_rd ? 3'd0 : seq_q;
    if (evt_valid) seq_n = evt_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      intr_q <= '0;
      seq_q  <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      intr_q <= intr_n;
      seq_q  <= seq_n;
      if (irq != (intr_n != 8'h00)) irq <= (intr_n != 8'h00);
    end
  end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        dma_step,
  input  logic        evt_valid,
  input  logic [6:0]  evt_stat,
  input  logic [7:0]  evt_intr,
  input  logic [2:0]  evt_seq,
  output logic        irq,
  output logic        fifo_ovf
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [TC_NB-1:0] wr_cnt;
  logic             wr_fifo, wr_cmd, wr_cfg1, rd_fifo, rd_intr;
  logic             cmd_reload, cmd_flush, xfer_byte, hit_zero;
  logic [TC_W-1:0]  tc_q, stc_q;
  logic [7:0]       cmd_q, cfg1_q, fifo_dout, rd_val, rdata_q;
  logic [CW-1:0]    fifo_cnt;
  logic [6:0]       stat_q;
  logic [7:0]       intr_q;
  logic [2:0]       seq_q;
  logic             hi_written;

  assign wr_cnt     = {bus_wr && bus_addr == A_CNT_HI,
                       bus_wr && bus_addr == A_CNT_MID,
                       bus_wr && bus_addr == A_CNT_LO};
  assign wr_fifo    = bus_wr && bus_addr == A_FIFO;
  assign wr_cmd     = bus_wr && bus_addr == A_CMD;
  assign wr_cfg1    = bus_wr && bus_addr == A_CFG1;
  assign rd_fifo    = bus_rd && bus_addr == A_FIFO;
  assign rd_intr    = bus_rd && bus_addr == A_INTR;
  assign cmd_reload = wr_cmd && bus_wdata[CMD_DMA];
  assign cmd_flush  = wr_cmd && bus_wdata[6:0] == OP_FLUSH;
  assign xfer_byte  = wr_fifo && cmd_q == {1'b0, OP_XFER};

  scsi_regif_tc u_tc (
    .clk(clk), .rst_n(rst_n), .shadow_we(wr_cnt), .wdata(bus_wdata),
    .reload(cmd_reload), .step(dma_step), .tc_q(tc_q), .stc_q(stc_q),
    .hit_zero(hit_zero)
  );

  scsi_regif_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_fifo), .pop(rd_fifo),
    .flush(cmd_flush), .din(bus_wdata), .dout(fifo_dout), .cnt(fifo_cnt),
    .ovf(fifo_ovf)
  );

  scsi_regif_irqs u_irqs (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_stat(evt_stat),
    .evt_intr(evt_intr), .evt_seq(evt_seq), .intr_rd(rd_intr),
    .tc_clr(|wr_cnt), .tc_set(hit_zero), .xfer_byte(xfer_byte),
    .stat_q(stat_q), .intr_q(intr_q), .seq_q(seq_q), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cfg1_q     <= CFG1_RST;
      hi_written <= 1'b0;
    end else begin
      if (wr_cmd)  cmd_q  <= bus_wdata;
      if (wr_cfg1) cfg1_q <= bus_wdata;
      if (wr_cnt[TC_NB-1]) hi_written <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO:  rd_val = tc_q[7:0];
      A_CNT_MID: rd_val = tc_q[15:8];
      A_CNT_HI:  rd_val = hi_written ? tc_q[23:16] : CHIP_ID;
      A_FIFO:    rd_val = fifo_dout;
      A_CMD:     rd_val = cmd_q;
      A_STAT:    rd_val = {irq, stat_q};
      A_INTR:    rd_val = intr_q;
      A_SEQ:     rd_val = {5'd0, seq_q};
      A_FLAGS:   rd_val = {{(8-CW){1'b0}}, fifo_cnt};
      A_CFG1:    rd_val = cfg1_q;
      default:   rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk
  import scsi_regif_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reload,
  input logic            step,
  input logic            hit_zero,
  input logic [TC_W-1:0] tc_q,
  input logic [TC_W-1:0] stc_q,
  input logic [TC_NB-1:0] wr_cnt,
  input logic            rd_intr,
  input logic            evt_valid,
  input logic [6:0]      stat_q,
  input logic [7:0]      intr_q,
  input logic [2:0]      seq_q,
  input logic            wr_fifo,
  input logic            rd_fifo,
  input logic [CW-1:0]   fifo_cnt,
  input logic            fifo_ovf,
  input logic            irq
);
  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> tc_q == tc_reload($past(stc_q)));

  // R4
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && tc_q != '0) |=> tc_q == $past(tc_q) - TC_W'(1));

  // R2
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_cnt) && !evt_valid && !hit_zero) |=> !stat_q[ST_TC]);

  // R5
  intr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_intr && !evt_valid && !hit_zero) |=>
      (intr_q == 8'h00 && seq_q == 3'd0 && !stat_q[ST_TC]));

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fifo && fifo_cnt == CW'(DEPTH)) |=> (fifo_ovf && $stable(fifo_cnt)));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fifo && fifo_cnt == '0) |=> fifo_cnt == '0);

  // R12
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (intr_q != 8'h00));
endmodule

bind scsi_regif scsi_regif_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload(cmd_reload), .step(dma_step),
  .hit_zero(hit_zero), .tc_q(tc_q), .stc_q(stc_q), .wr_cnt(wr_cnt),
  .rd_intr(rd_intr), .evt_valid(evt_valid), .stat_q(stat_q),
  .intr_q(intr_q), .seq_q(seq_q), .wr_fifo(wr_fifo), .rd_fifo(rd_fifo),
  .fifo_cnt(fifo_cnt), .fifo_ovf(fifo_ovf), .irq(irq)
);

// File: tb/tb_scsi_regif.sv
`timescale 1ns/1ps
module tb_scsi_regif;
  localparam logic [3:0] T_LO = 4'h0, T_MID = 4'h1, T_HI = 4'h9, T_FIFO = 4'h2,
                         T_CMD = 4'h3, T_STAT = 4'h4, T_INTR = 4'h5,
                         T_SEQ = 4'h6, T_FLAGS = 4'h7, T_CFG1 = 4'h8;
  localparam logic [7:0] T_CHIP = 8'hA2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, dma_step = 0, evt_valid = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, evt_intr = 0;
  logic [6:0] evt_stat = 0;
  logic [2:0] evt_seq = 0;
  logic irq, fifo_ovf, last_ovf;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scsi_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_step(dma_step), .evt_valid(evt_valid), .evt_stat(evt_stat),
    .evt_intr(evt_intr), .evt_seq(evt_seq), .irq(irq), .fifo_ovf(fifo_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; last_ovf = fifo_ovf;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic step1();
    @(negedge clk); dma_step = 1;
    @(negedge clk); dma_step = 0;
  endtask

  task automatic evt(input logic [6:0] s, input logic [7:0] i, input logic [2:0] q);
    @(negedge clk); evt_valid = 1; evt_stat = s; evt_intr = i; evt_seq = q;
    @(negedge clk); evt_valid = 0;
  endtask

  task automatic load_tc(input logic [23:0] v);
    wr(T_LO, v[7:0]); wr(T_MID, v[15:8]); wr(T_HI, v[23:16]);
    wr(T_CMD, 8'h80);
  endtask

  task automatic chk_tc(input string tag, input logic [23:0] exp);
    rdchk(tag, T_LO, exp[7:0]);
    rdchk(tag, T_MID, exp[15:8]);
    rdchk(tag, T_HI, exp[23:16]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [23:0] vals [7];
    vals = '{24'h000000, 24'h000001, 24'h0000FF, 24'h012345,
             24'hFFFFFF, 24'h800000, 24'h00FF00};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 reset state
    chk("R13 irq", irq, 0);
    rdchk("R13 stat", T_STAT, 8'h00);
    rdchk("R13 intr", T_INTR, 8'h00);
    rdchk("R13 seq", T_SEQ, 8'h00);
    rdchk("R13 flags", T_FLAGS, 8'h00);
    rdchk("R13 cfg1", T_CFG1, 8'h07);
    rdchk("R13 lo", T_LO, 8'h00);
    rdchk("R13 mid", T_MID, 8'h00);
    // R7 chip id before first high write
    rdchk("R7 chip id", T_HI, T_CHIP);

    // R1 shadow writes do not reach the live counter
    wr(T_LO, 8'h11); wr(T_MID, 8'h22);
    rdchk("R1 lo live", T_LO, 8'h00);
    rdchk("R1 mid live", T_MID, 8'h00);
    rdchk("R7 still id", T_HI, T_CHIP);
    wr(T_HI, 8'h05);
    rdchk("R7 after write", T_HI, 8'h00);
    wr(T_STAT, 8'hFF);
    rdchk("R1 ro ignored", T_STAT, 8'h00);

    // R3 reload sweep
    foreach (vals[k]) begin
      load_tc(vals[k]);
      chk_tc("R3 reload", (vals[k] == 0) ? 24'h010000 : vals[k]);
    end

    // R10 nop and non-DMA flush leave the counter alone
    load_tc(24'h000042);
    wr(T_LO, 8'h99);
    wr(T_CMD, 8'h00);
    chk_tc("R10 nop", 24'h000042);
    wr(T_CMD, 8'h01);
    chk_tc("R10 flush no reload", 24'h000042);

    // R4 decrement to zero sets TC, saturates
    load_tc(24'h000005);
    for (int i = 1; i <= 5; i++) begin
      step1();
      rdchk("R4 dec", T_LO, 8'(5 - i));
    end
    rdchk("R4 tc set", T_STAT, 8'h10);
    step1();
    chk_tc("R4 saturate", 24'h000000);
    // R2 count write clears TC
    wr(T_MID, 8'h00);
    rdchk("R2 tc clr", T_STAT, 8'h00);
    load_tc(24'h000000);
    step1();
    chk_tc("R4 from 0x10000", 24'h00FFFF);

    // R6/R8 fill sweep
    for (int n = 0; n <= 16; n++) begin
      wr(T_CMD, 8'h01);
      for (int i = 0; i < n; i++) wr(T_FIFO, 8'((8'h30 + i) ^ n));
      rdchk("R6 flags", T_FLAGS, 8'(n));
      for (int i = 0; i < n; i++) rdchk("R8 order", T_FIFO, 8'((8'h30 + i) ^ n));
      rdchk("R6 flags empty", T_FLAGS, 8'h00);
    end
    rdchk("R11 no intr other cmd", T_INTR, 8'h00);

    // R8 overrun
    wr(T_CMD, 8'h01);
    for (int i = 0; i < 18; i++) begin
      wr(T_FIFO, 8'hA0 + 8'(i));
      chk("R8 ovf pulse", last_ovf, (i >= 16) ? 1 : 0);
    end
    rdchk("R8 full flags", T_FLAGS, 8'd16);
    for (int i = 0; i < 16; i++) rdchk("R8 kept", T_FIFO, 8'hA0 + 8'(i));

    // R9 empty pop
    rdchk("R9 empty data", T_FIFO, 8'h00);
    rdchk("R9 empty count", T_FLAGS, 8'h00);

    // R10 flush
    for (int i = 0; i < 5; i++) wr(T_FIFO, 8'(i));
    wr(T_CMD, 8'h01);
    rdchk("R10 flush", T_FLAGS, 8'h00);

    // R11 non-DMA transfer byte interrupts
    wr(T_CMD, 8'h10);
    rdchk("R11 pre", T_INTR, 8'h00);
    wr(T_FIFO, 8'h5A);
    chk("R12 irq up", irq, 1);
    rdchk("R12 stat int", T_STAT, 8'h80);
    rdchk("R11 bits", T_INTR, 8'h18);
    chk("R12 irq down", irq, 0);
    rdchk("R5 intr cleared", T_INTR, 8'h00);
    wr(T_CMD, 8'h90);
    wr(T_FIFO, 8'h5B);
    rdchk("R11 dma no intr", T_INTR, 8'h00);

    // R14 core event, R5 read clears
    evt(7'h10, 8'h01, 3'd3);
    chk("R14 irq", irq, 1);
    rdchk("R14 seq", T_SEQ, 8'h03);
    rdchk("R14 stat", T_STAT, 8'h90);
    evt(7'h02, 8'h04, 3'd4);
    chk("R12 irq held", irq, 1);
    rdchk("R14 stat or", T_STAT, 8'h92);
    rdchk("R5 value", T_INTR, 8'h05);
    chk("R5 irq", irq, 0);
    rdchk("R5 stat", T_STAT, 8'h02);
    rdchk("R5 seq", T_SEQ, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule